// File: doc/BRIEF.md
# Double-Buffered Calendar Clock Register Block

This block keeps calendar time in two banks. A hidden counting bank advances seconds, minutes, hours, day of week, date, month and year in packed BCD. A second bank is what a host sees through a small parallel register port. That port has an address, write data, read data, a write strobe and a read strobe. In normal operation the visible bank copies the counting bank on every clock, so the host reads current time.

The host can freeze the visible bank to read a consistent snapshot while the counting bank keeps running. It can also stage a new time in the visible bank and commit it in one step. An oscillator stop bit, held in the seconds register, pauses timekeeping. A frequency test output shows a square wave at 512 Hz of the oscillator tick when its enabling conditions hold. The block is clocked by a fast system clock. The slow oscillator arrives as a one-cycle enable pulse, `osc_tick`, at 32.768 kHz by default.

Top module: `rtc_dualbank`

## Requirements
- R1: After reset, the control register (address 0) reads 00h and the seconds register (address 1) reads 80h, with bit 7 set meaning stopped. Minutes, hours and year (addresses 2, 3, 7) read 00h. Day (4), date (5) and month (6) read 01h. The test configuration register (address 8) reads 00h and `ft_out` is 0.
- R2: While seconds bit 7 is 1, no time field advances. Writing bit 7 of address 1 takes effect whether or not the write bit is set. Once the bit is cleared, seconds advance by one for every TICKS_PER_SEC ticks.
- R3: Seconds and minutes roll from 59h to 00h, and hours roll from 23h to 00h. Each rollover carries into the next field.
- R4: Date rolls to 01h after 31h, 30h (April, June, September, November), 28h (February) or 29h (February in a year whose BCD value is divisible by 4). Month rolls from 12h to 01h, year from 99h to 00h, and day of week from 07h to 01h.
- R5: While control bit 6 (the read bit) is 1, the visible bank holds the time it had when the bit was set, and the counting bank keeps advancing.
- R6: After the read bit is cleared, the visible bank stays frozen until SETTLE_TICKS ticks have been counted from that cycle. Setting the read bit again restarts the count.
- R7: While control bit 7 (the write bit) is 1, host writes to addresses 1 to 7 land in the visible bank and nothing overwrites them. Writes to those addresses while the write bit is 0 change no time field. Clearing the write bit loads the visible bank into the counting bank, restarts the sub-second divider, and counting resumes from the loaded value.
- R8: When a carry crosses several fields, the visible bank takes all of them on the same clock edge.
- R9: `ft_out` toggles every TICKS_PER_SEC/(2*FT_HZ) ticks only when four conditions hold together: the oscillator runs, config bit 0 (test enable) is 1, config bit 1 (alarm enable) is 0, and either config bit 2 (steering) is 1 or the watchdog value register (address 9) is 00h. Otherwise `ft_out` is 0.
- R10: A read strobe returns the addressed register on `bus_rdata` one cycle later. Addresses 8 and 9 read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| ft_out | output | 1 | Frequency test square wave |

## Verification
Read data is due one clock after the read strobe. The scoreboard monitor therefore pops an expected byte on the falling edge that follows each edge at which the strobe was sampled.

A second advance is due TICKS_PER_SEC ticks after a commit, and the bench ticks every other clock. Time checks are therefore placed about 3000 clocks after a commit, well clear of the first advance at 2048 clocks and the second at 4096. The settle window is 34 clocks. Frozen reads come about 20 clocks after the read bit clears and resumed reads about 80 clocks after.

The test output changes one clock after a tick, so toggles are counted over 64 falling-edge intervals. Exactly 32 toggles are expected whatever the phase.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{
    year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
    hour: 8'h00, min: 8'h00, sec: 8'h00
  };

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // tens*10+ones is divisible by 4 exactly when 2*tens+ones is
  function automatic logic leap_year(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] month,
                                           input logic [7:0] year);
    logic [7:0] r;
    case (month)
      8'h02:                      r = leap_year(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic rtc_time_t next_time(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec == 8'h59) begin
      n.sec = 8'h00;
      if (t.min == 8'h59) begin
        n.min = 8'h00;
        if (t.hour == 8'h23) begin
          n.hour = 8'h00;
          n.dow  = (t.dow == 8'h07) ? 8'h01 : bcd_inc(t.dow);
          if (t.date == last_date(t.month, t.year)) begin
            n.date = 8'h01;
            if (t.month == 8'h12) begin
              n.month = 8'h01;
              n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end else begin
              n.month = bcd_inc(t.month);
            end
          end else begin
            n.date = bcd_inc(t.date);
          end
        end else begin
          n.hour = bcd_inc(t.hour);
        end
      end else begin
        n.min = bcd_inc(t.min);
      end
    end else begin
      n.sec = bcd_inc(t.sec);
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FT_HALF       = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic sec_pulse,
  output logic ft_phase
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam int FW = $clog2(FT_HALF + 1);
  localparam logic [CW-1:0] LAST  = CW'(TICKS_PER_SEC - 1);
  localparam logic [FW-1:0] FLAST = FW'(FT_HALF - 1);

  logic [CW-1:0] cnt;
  logic [FW-1:0] fcnt;
  logic          phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (tick && run)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt  <= '0;
      phase <= 1'b0;
    end else if (tick && run) begin
      if (fcnt == FLAST) begin
        fcnt  <= '0;
        phase <= ~phase;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign sec_pulse = tick && run && !restart && (cnt == LAST);
  assign ft_phase  = phase;
endmodule

// File: rtl/rtc_count.sv
module rtc_count
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  rtc_time_t load_val,
  input  logic      advance,
  output rtc_time_t now
);
  rtc_time_t cur;

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= RTC_RESET_TIME;
    else if (load)    cur <= load_val;
    else if (advance) cur <= next_time(cur);
  end

  assign now = cur;
endmodule

// File: rtl/rtc_settle.sv
module rtc_settle #(
  parameter int SETTLE_TICKS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic done
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] FULL = SW'(SETTLE_TICKS);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= FULL;
    else if (hold)                 cnt <= '0;
    else if (tick && cnt != FULL)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == FULL);
endmodule

// File: rtl/rtc_dualbank.sv
module rtc_dualbank
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int FT_HZ         = 512,
  parameter int SETTLE_TICKS  = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       ft_out
);
  localparam int FT_HALF = TICKS_PER_SEC / (2 * FT_HZ);

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_SEC   = 4'd1;
  localparam logic [3:0] A_MIN   = 4'd2;
  localparam logic [3:0] A_HOUR  = 4'd3;
  localparam logic [3:0] A_DOW   = 4'd4;
  localparam logic [3:0] A_DATE  = 4'd5;
  localparam logic [3:0] A_MONTH = 4'd6;
  localparam logic [3:0] A_YEAR  = 4'd7;
  localparam logic [3:0] A_CFG   = 4'd8;
  localparam logic [3:0] A_WDOG  = 4'd9;

  logic       write_bit, read_bit, osc_stop;
  logic       ft_bit, ae_bit, wds_bit;
  logic [7:0] wdog_q;
  rtc_time_t  ext_q;
  rtc_time_t  int_time;
  logic [7:0] rdata_q;

  // named internal events
  logic run_en, sec_pulse, settle_done, ft_phase;
  logic mirror_en, host_time_wr, commit, ft_enable;

  assign run_en       = !osc_stop;
  assign host_time_wr = bus_wr && write_bit &&
                        (bus_addr >= A_SEC) && (bus_addr <= A_YEAR);
  assign commit       = bus_wr && (bus_addr == A_CTRL) && write_bit && !bus_wdata[7];
  assign mirror_en    = !read_bit && !write_bit && settle_done;
  assign ft_enable    = run_en && ft_bit && !ae_bit && (wds_bit || (wdog_q == 8'h00));

  rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .FT_HALF(FT_HALF)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .run(run_en),
    .restart(commit), .sec_pulse(sec_pulse), .ft_phase(ft_phase)
  );

  rtc_count u_cnt (
    .clk(clk), .rst_n(rst_n), .load(commit), .load_val(ext_q),
    .advance(sec_pulse), .now(int_time)
  );

  rtc_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_set (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .hold(read_bit), .done(settle_done)
  );

  // control, oscillator and test configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_bit <= 1'b0;
      read_bit  <= 1'b0;
      osc_stop  <= 1'b1;
      ft_bit    <= 1'b0;
      ae_bit    <= 1'b0;
      wds_bit   <= 1'b0;
      wdog_q    <= 8'h00;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          write_bit <= bus_wdata[7];
          read_bit  <= bus_wdata[6];
        end
        A_SEC:  osc_stop <= bus_wdata[7];
        A_CFG: begin
          ft_bit  <= bus_wdata[0];
          ae_bit  <= bus_wdata[1];
          wds_bit <= bus_wdata[2];
        end
        A_WDOG: wdog_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // visible bank: staged by host or copied whole from the counting bank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= RTC_RESET_TIME;
    end else if (host_time_wr) begin
      case (bus_addr)
        A_SEC:   ext_q.sec   <= {1'b0, bus_wdata[6:0]};
        A_MIN:   ext_q.min   <= bus_wdata;
        A_HOUR:  ext_q.hour  <= bus_wdata;
        A_DOW:   ext_q.dow   <= bus_wdata;
        A_DATE:  ext_q.date  <= bus_wdata;
        A_MONTH: ext_q.month <= bus_wdata;
        default: ext_q.year  <= bus_wdata;
      endcase
    end else if (mirror_en) begin
      ext_q <= int_time;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  rdata_q <= {write_bit, read_bit, 6'b0};
        A_SEC:   rdata_q <= {osc_stop, ext_q.sec[6:0]};
        A_MIN:   rdata_q <= ext_q.min;
        A_HOUR:  rdata_q <= ext_q.hour;
        A_DOW:   rdata_q <= ext_q.dow;
        A_DATE:  rdata_q <= ext_q.date;
        A_MONTH: rdata_q <= ext_q.month;
        A_YEAR:  rdata_q <= ext_q.year;
        A_CFG:   rdata_q <= {5'b0, wds_bit, ae_bit, ft_bit};
        A_WDOG:  rdata_q <= wdog_q;
        default: rdata_q <= 8'h00;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign ft_out    = ft_enable && ft_phase;
endmodule

// File: rtl/rtc_dualbank_chk.sv
module rtc_dualbank_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      osc_stop,
  input logic      sec_pulse,
  input logic      mirror_en,
  input logic      host_time_wr,
  input logic      read_bit,
  input logic      commit,
  input rtc_time_t int_time,
  input rtc_time_t ext_q,
  input logic      ft_enable,
  input logic      ft_out
);
  // R2: a stopped oscillator produces no second pulse
  a_r2_stopped_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> !sec_pulse);

  // R3: seconds wrap from 59 to 00
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !commit && int_time.sec == 8'h59) |=> (int_time.sec == 8'h00));

  // R5: a halted visible bank changes only through host staging
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mirror_en) && !$past(host_time_wr)) |-> $stable(ext_q));

  // R6: the cycle the read bit clears, mirroring is still held off
  a_r6_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_bit) |-> !mirror_en);

  // R7: a commit loads the counting bank from the visible bank
  a_r7_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(commit) |-> (int_time == $past(ext_q)));

  // R8: a minute change in the tracking bank always comes with seconds 00
  a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mirror_en) && $past(mirror_en, 2) && !$past(host_time_wr) &&
     ext_q.min != $past(ext_q.min)) |-> (ext_q.sec == 8'h00));

  // R9: no test wave unless all enabling conditions hold
  a_r9_ft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ft_enable |-> !ft_out);
endmodule

bind rtc_dualbank rtc_dualbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_stop(osc_stop), .sec_pulse(sec_pulse),
  .mirror_en(mirror_en), .host_time_wr(host_time_wr), .read_bit(read_bit),
  .commit(commit), .int_time(int_time), .ext_q(ext_q),
  .ft_enable(ft_enable), .ft_out(ft_out)
);

// File: tb/rtc_dualbank_test.sv
module rtc_dualbank_test;
  localparam int TPS = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ft_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) osc_tick <= 1'b0;
    else        osc_tick <= ~osc_tick;
  end

  rtc_dualbank #(.TICKS_PER_SEC(TPS), .FT_HZ(512), .SETTLE_TICKS(17)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .ft_out(ft_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one clock after the strobe
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(bus_rdata), int'(e));
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] mi,
                           input logic [7:0] h, input logic [7:0] dw,
                           input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] y);
    wr(4'd0, 8'h80);
    wr(4'd1, s); wr(4'd2, mi); wr(4'd3, h); wr(4'd4, dw);
    wr(4'd5, dt); wr(4'd6, mo); wr(4'd7, y);
    wr(4'd0, 8'h00);
  endtask

  task automatic count_toggles(input int n, output int tog);
    logic prev;
    tog = 0;
    @(negedge clk);
    prev = ft_out;
    repeat (n) begin
      @(negedge clk);
      if (ft_out !== prev) tog++;
      prev = ft_out;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tog;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R10 map
    check("R1 ft_out after reset", int'(ft_out), 0);
    rd_expect(4'd0, 8'h00, "R1 ctrl reset");
    rd_expect(4'd1, 8'h80, "R1 seconds reset stopped");
    rd_expect(4'd2, 8'h00, "R1 minutes reset");
    rd_expect(4'd3, 8'h00, "R1 hours reset");
    rd_expect(4'd4, 8'h01, "R1 dow reset");
    rd_expect(4'd5, 8'h01, "R1 date reset");
    rd_expect(4'd6, 8'h01, "R1 month reset");
    rd_expect(4'd7, 8'h00, "R1 year reset");
    rd_expect(4'd8, 8'h00, "R1 cfg reset");

    // R2 stopped oscillator does not count
    wait_cycles(3000);
    rd_expect(4'd1, 8'h80, "R2 stopped seconds");

    // R7 staging, then R3/R4 rollover
    wr(4'd0, 8'h80);
    wr(4'd1, 8'h59); wr(4'd2, 8'h59); wr(4'd3, 8'h23); wr(4'd4, 8'h07);
    wr(4'd5, 8'h28); wr(4'd6, 8'h02); wr(4'd7, 8'h03);
    rd_expect(4'd1, 8'h59, "R7 staged seconds visible");
    rd_expect(4'd0, 8'h80, "R7 write bit readback");
    wait_cycles(100);
    rd_expect(4'd5, 8'h28, "R7 staged date not overwritten");
    wr(4'd0, 8'h00);
    wait_cycles(3000);
    rd_expect(4'd1, 8'h00, "R3 seconds wrap");
    rd_expect(4'd2, 8'h00, "R3 minutes wrap");
    rd_expect(4'd3, 8'h00, "R3 hours wrap");
    rd_expect(4'd4, 8'h01, "R4 dow 7 to 1");
    rd_expect(4'd5, 8'h01, "R4 Feb 28 non-leap");
    rd_expect(4'd6, 8'h03, "R4 month to March");
    rd_expect(4'd7, 8'h03, "R7 committed year");

    // R4 leap February
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h04);
    wait_cycles(3000);
    rd_expect(4'd5, 8'h29, "R4 leap Feb 29");
    rd_expect(4'd6, 8'h02, "R4 leap month kept");
    rd_expect(4'd4, 8'h04, "R4 dow increments");

    // R4 year wrap
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    wait_cycles(3000);
    rd_expect(4'd7, 8'h00, "R4 year 99 to 00");
    rd_expect(4'd6, 8'h01, "R4 month 12 to 01");
    rd_expect(4'd5, 8'h01, "R4 date to 01");

    // R4 thirty-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h05);
    wait_cycles(3000);
    rd_expect(4'd5, 8'h01, "R4 April 30 wrap");
    rd_expect(4'd6, 8'h05, "R4 month to May");

    // R3 minute carry without hour carry
    load_time(8'h59, 8'h34, 8'h12, 8'h02, 8'h10, 8'h05, 8'h05);
    wait_cycles(3000);
    rd_expect(4'd2, 8'h35, "R3 minute carry");
    rd_expect(4'd3, 8'h12, "R3 hour kept");

    // R5 / R6 freeze and settle
    load_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h15, 8'h06, 8'h10);
    wr(4'd0, 8'h40);
    wait_cycles(2900);
    rd_expect(4'd1, 8'h00, "R5 frozen snapshot");
    wr(4'd0, 8'h00);
    wait_cycles(20);
    rd_expect(4'd1, 8'h00, "R6 still frozen in settle");
    wr(4'd0, 8'h40);
    wr(4'd0, 8'h00);
    wait_cycles(20);
    rd_expect(4'd1, 8'h00, "R6 settle restarted");
    wait_cycles(60);
    rd_expect(4'd1, 8'h01, "R5 internal kept counting, R6 resumed");

    // R2 stop while running, R7 ignored writes without write bit
    wr(4'd1, 8'h80);
    wr(4'd2, 8'h45);
    wait_cycles(3000);
    rd_expect(4'd1, 8'h81, "R2 stopped holds seconds");
    rd_expect(4'd2, 8'h00, "R7 write without write bit ignored");

    // R9 frequency test
    wr(4'd8, 8'h01);
    count_toggles(40, tog);
    check("R9 no toggle while stopped", tog, 0);
    wr(4'd1, 8'h00);
    count_toggles(64, tog);
    check("R9 toggles when enabled", tog, 32);
    wr(4'd8, 8'h03);
    count_toggles(64, tog);
    check("R9 alarm enable blocks", tog, 0);
    check("R9 output low when blocked", int'(ft_out), 0);
    wr(4'd8, 8'h01);
    wr(4'd9, 8'h05);
    count_toggles(64, tog);
    check("R9 nonzero watchdog blocks", tog, 0);
    wr(4'd8, 8'h05);
    count_toggles(64, tog);
    check("R9 steering bit enables", tog, 32);
    rd_expect(4'd8, 8'h05, "R10 cfg readback");
    rd_expect(4'd9, 8'h05, "R10 watchdog readback");

    wait_cycles(3);
    if (exp_q.size() != 0) check("R10 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule